// File: doc/BRIEF.md
# Dual-Channel Vectored Interrupt Controller

This block collects interrupt lines from peripherals and presents them to a processor on two independent channels. The normal channel has sixteen inputs, and the fast channel has eight. Each input passes through a synchronizer. Each input is then treated either as a rising-edge event, which is latched until it is serviced, or as a high-level condition, which is pending while the line is high. Every channel has a mask register that decides which pending sources may raise the channel's request line. A vector register reports the number of the winning source. The lowest-numbered source that is both pending and unmasked wins.

Software reaches the block through a small register bus. The read data is combinational and the side effects take place at a clock edge. The vector register of each channel can be read at two word addresses. A read at the first address acknowledges the winning source: an edge source loses its pending bit, and the channel enters service. While the channel is in service, its request line stays low until software writes the end-of-interrupt register. A read at the second address returns the same number without changing any state.

Two of the fast-channel inputs, numbers 6 and 7, have no pins of their own. Each one takes its line from a normal-channel input chosen by a route register. This lets urgent normal sources be promoted to the fast channel. Normal inputs 7 and 14 are reserved and never become pending.

Top module: `vic_dual`

Register map (4-bit word address; bit 3 selects the fast channel):

| Address | Register |
|---|---|
| 0x0 / 0x8 | Enable mask (1 = unmasked) |
| 0x1 / 0x9 | Trigger mode (1 = level, 0 = rising edge) |
| 0x2 / 0xA | Pending (read; write 1 to clear) |
| 0x3 / 0xB | End-of-interrupt (any write) |
| 0x4 / 0xC | Vector, acknowledging read |
| 0x5 / 0xD | Vector, observing read |
| 0xE | Route: bits [3:0] give the source for fast input 6, bits [11:8] give the source for fast input 7 |

## Requirements
- R1: After reset, both masks read 0 and both pending registers read 0. The normal trigger register reads 0x0100, with only input 8 in level mode, and the fast trigger register reads 0. Both request outputs are low. The normal vector reads 0x1F and the fast vector reads 0x0F.
- R2: A rising edge on an input in edge mode sets its pending bit. This holds for a pulse only two clock cycles long, and the bit stays set after the input returns low.
- R3: In level mode, a pending bit follows the synchronized input: it is set while the input is high and clears after the input falls.
- R4: A pending bit whose mask bit is 0 is still shown in the pending register. It does not raise the channel request, and it is not reported by the vector.
- R5: The vector is the lowest-numbered source that is both pending and unmasked. With none, it reads all ones: 5 bits (0x1F) on the normal channel and 4 bits (0x0F) on the fast channel.
- R6: A read at the acknowledging address returns the vector. In an edge-mode source it clears the winner's pending bit. A level-mode source stays pending. Either way, the read puts the channel in service and drops its request output.
- R7: A read at the observing address returns the same vector and changes no pending bit or service state.
- R8: A write to a channel's end-of-interrupt register ends service, and the request output returns if an unmasked source is pending.
- R9: Writing 1 to a bit of the pending register clears that edge-mode pending bit. Bits written as 0 are unchanged.
- R10: Normal inputs 7 and 14 never become pending, whatever their input level.
- R11: Fast inputs 6 and 7 take their line from the normal input named in route bits [3:0] and [11:8] respectively.
- R12: Further rising edges on a source that is already pending are absorbed: one acknowledge clears it.
- Timing: an input change reaches the pending, request and vector outputs on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nrmIrqIn | input | 16 | Normal-channel interrupt lines |
| fstIrqIn | input | 6 | Fast-channel interrupt lines 0 to 5 |
| busAddr | input | 4 | Register word address |
| busWr | input | 1 | Write strobe, one cycle |
| busRd | input | 1 | Read strobe, one cycle |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data, combinational from busAddr |
| nrmReq | output | 1 | Normal-channel request to the processor |
| fstReq | output | 1 | Fast-channel request to the processor |

## Verification
Each result is due at a known point:

- **Input changes:** an interrupt input change shows in the pending, vector and request outputs only after three rising edges, two for synchronization and one for the pending latch. The bench waits four cycles after every input change before it reads anything back.
- **Register writes and acknowledges:** these act on the edge that ends their one-cycle strobe. Request outputs are checked at the following falling edge.
- **Read data:** it is combinational. The monitor compares it a quarter period after the falling edge in which the read strobe is driven, before the acknowledging edge changes any state.

// File: rtl/vic_pkg.sv
package vic_pkg;

  typedef struct packed {
    logic maskWr;
    logic trigWr;
    logic pendClr;
    logic ack;
  } chanCmd_t;

  localparam int REG_AW = 4;

  localparam logic [2:0] OFS_MASK  = 3'd0;
  localparam logic [2:0] OFS_TRIG  = 3'd1;
  localparam logic [2:0] OFS_PEND  = 3'd2;
  localparam logic [2:0] OFS_EOI   = 3'd3;
  localparam logic [2:0] OFS_VACK  = 3'd4;
  localparam logic [2:0] OFS_VPEEK = 3'd5;

  localparam logic [REG_AW-1:0] ADDR_ROUTE = 4'hE;

endpackage

// File: rtl/vic_chan_dp.sv
module vic_chan_dp
  import vic_pkg::*;
#(
  parameter int          N           = 16,
  parameter int          VEC_W       = 5,
  parameter int          SYNC_STAGES = 2,
  parameter logic [N-1:0] TRIG_RST   = '0,
  parameter logic [N-1:0] RSVD       = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     irqIn,
  input  chanCmd_t         cmd,
  input  logic [N-1:0]     wData,
  output logic [N-1:0]     maskQ,
  output logic [N-1:0]     trigQ,
  output logic [N-1:0]     pendQ,
  output logic [VEC_W-1:0] vecIdx,
  output logic             vecValid
);

  logic [N-1:0] syncQ [SYNC_STAGES];
  logic [N-1:0] prevQ;
  logic [N-1:0] lineNow;
  logic [N-1:0] rise;
  logic [N-1:0] active;
  logic [N-1:0] wClr;
  logic [N-1:0] aClr;

  // input synchronizer and previous-value register for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= irqIn & ~RSVD;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign lineNow = syncQ[SYNC_STAGES-1];
  assign rise    = lineNow & ~prevQ;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      trigQ <= TRIG_RST;
    end else begin
      if (cmd.maskWr) maskQ <= wData;
      if (cmd.trigWr) trigQ <= wData;
    end
  end

  assign wClr = cmd.pendClr ? wData : '0;
  assign aClr = (cmd.ack && vecValid) ? ((N'(1) << vecIdx) & ~trigQ) : '0;

  // pending latches: a new edge wins over a clear in the same cycle
  for (genvar i = 0; i < N; i++) begin : g_pend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            pendQ[i] <= 1'b0;
      else if (RSVD[i])     pendQ[i] <= 1'b0;
      else if (trigQ[i])    pendQ[i] <= lineNow[i];
      else                  pendQ[i] <= (pendQ[i] & ~wClr[i] & ~aClr[i]) | rise[i];
    end

    // R2 / R12: a latched edge stays pending until cleared
    a_r2_edge_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!trigQ[i] && pendQ[i] && !cmd.pendClr && !cmd.ack && !cmd.trigWr) |=> pendQ[i]);

    // R3: level source mirrors the synchronized line
    a_r3_level_follow: assert property (@(posedge clk) disable iff (!rstN)
      (trigQ[i] && !cmd.trigWr && !RSVD[i]) |=> (pendQ[i] == $past(lineNow[i])));
  end

  assign active = pendQ & maskQ;

  // fixed priority: lowest index wins, all ones when idle
  always_comb begin
    vecIdx   = '1;
    vecValid = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (active[i]) begin
        vecIdx   = VEC_W'(i);
        vecValid = 1'b1;
      end
    end
  end

  // R5: reported source is really pending and unmasked
  a_r5_vec_active: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (pendQ[vecIdx] && maskQ[vecIdx]));

  // R10: reserved sources never show pending
  a_r10_rsvd_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ & RSVD) == '0);

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NRM_N  = 16,
  parameter int FST_N  = 8,
  parameter int NRM_VW = 5,
  parameter int FST_VW = 4,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [NRM_N-1:0]  busWData,
  output logic [NRM_N-1:0]  busRData,
  output chanCmd_t          nrmCmd,
  output chanCmd_t          fstCmd,
  input  logic [NRM_N-1:0]  nrmMask,
  input  logic [NRM_N-1:0]  nrmTrig,
  input  logic [NRM_N-1:0]  nrmPend,
  input  logic [NRM_VW-1:0] nrmVec,
  input  logic              nrmValid,
  input  logic [FST_N-1:0]  fstMask,
  input  logic [FST_N-1:0]  fstTrig,
  input  logic [FST_N-1:0]  fstPend,
  input  logic [FST_VW-1:0] fstVec,
  input  logic              fstValid,
  output logic [SEL_W-1:0]  routeSel6,
  output logic [SEL_W-1:0]  routeSel7,
  output logic              nrmReq,
  output logic              fstReq
);

  localparam int DW = NRM_N;

  logic       isFst;
  logic [2:0] ofs;
  logic       routeHit;
  logic       nrmEoi, fstEoi;
  logic       nrmSvcQ, fstSvcQ;

  assign isFst    = busAddr[REG_AW-1];
  assign ofs      = busAddr[2:0];
  assign routeHit = (busAddr == ADDR_ROUTE);

  always_comb begin
    nrmCmd         = '0;
    fstCmd         = '0;
    nrmCmd.maskWr  = busWr && !isFst && (ofs == OFS_MASK);
    nrmCmd.trigWr  = busWr && !isFst && (ofs == OFS_TRIG);
    nrmCmd.pendClr = busWr && !isFst && (ofs == OFS_PEND);
    nrmCmd.ack     = busRd && !isFst && (ofs == OFS_VACK);
    fstCmd.maskWr  = busWr &&  isFst && (ofs == OFS_MASK);
    fstCmd.trigWr  = busWr &&  isFst && (ofs == OFS_TRIG);
    fstCmd.pendClr = busWr &&  isFst && (ofs == OFS_PEND);
    fstCmd.ack     = busRd &&  isFst && (ofs == OFS_VACK);
  end

  assign nrmEoi = busWr && !isFst && (ofs == OFS_EOI);
  assign fstEoi = busWr &&  isFst && (ofs == OFS_EOI);

  // in-service flags: an acknowledge with a valid vector sets, end-of-interrupt clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nrmSvcQ <= 1'b0;
      fstSvcQ <= 1'b0;
    end else begin
      if (nrmCmd.ack && nrmValid) nrmSvcQ <= 1'b1;
      else if (nrmEoi)            nrmSvcQ <= 1'b0;
      if (fstCmd.ack && fstValid) fstSvcQ <= 1'b1;
      else if (fstEoi)            fstSvcQ <= 1'b0;
    end
  end

  assign nrmReq = nrmValid && !nrmSvcQ;
  assign fstReq = fstValid && !fstSvcQ;

  // route selection register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routeSel6 <= '0;
      routeSel7 <= '0;
    end else if (busWr && routeHit) begin
      routeSel6 <= busWData[SEL_W-1:0];
      routeSel7 <= busWData[8+SEL_W-1:8];
    end
  end

  // read data mux
  always_comb begin
    busRData = '0;
    if (routeHit) begin
      busRData[SEL_W-1:0]   = routeSel6;
      busRData[8+SEL_W-1:8] = routeSel7;
    end else if (!isFst) begin
      unique case (ofs)
        OFS_MASK:            busRData = nrmMask;
        OFS_TRIG:            busRData = nrmTrig;
        OFS_PEND:            busRData = nrmPend;
        OFS_VACK, OFS_VPEEK: busRData = DW'(nrmVec);
        default:             busRData = '0;
      endcase
    end else begin
      unique case (ofs)
        OFS_MASK:            busRData = DW'(fstMask);
        OFS_TRIG:            busRData = DW'(fstTrig);
        OFS_PEND:            busRData = DW'(fstPend);
        OFS_VACK, OFS_VPEEK: busRData = DW'(fstVec);
        default:             busRData = '0;
      endcase
    end
  end

  // R6: an accepted acknowledge silences the channel request
  a_r6_nrm_ack_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (nrmCmd.ack && nrmValid) |=> !nrmReq);
  a_r6_fst_ack_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (fstCmd.ack && fstValid) |=> !fstReq);

  // R8: end-of-interrupt leaves the channel out of service
  a_r8_nrm_eoi: assert property (@(posedge clk) disable iff (!rstN)
    (nrmEoi && !nrmCmd.ack) |=> !nrmSvcQ);

  // R7: an observing read never changes service state
  a_r7_peek_clean: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && (ofs == OFS_VPEEK) && !busWr) |=> ($stable(nrmSvcQ) && $stable(fstSvcQ)));

endmodule

// File: rtl/vic_dual.sv
module vic_dual
  import vic_pkg::*;
#(
  parameter int              NRM_N        = 16,
  parameter int              FST_N        = 8,
  parameter int              SYNC_STAGES  = 2,
  parameter logic [NRM_N-1:0] NRM_RSVD    = 16'h4080,
  parameter logic [NRM_N-1:0] NRM_TRIG_RST = 16'h0100,
  parameter logic [FST_N-1:0] FST_TRIG_RST = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NRM_N-1:0]     nrmIrqIn,
  input  logic [FST_N-3:0]     fstIrqIn,
  input  logic [REG_AW-1:0]    busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [NRM_N-1:0]     busWData,
  output logic [NRM_N-1:0]     busRData,
  output logic                 nrmReq,
  output logic                 fstReq
);

  localparam int NRM_VW = $clog2(NRM_N) + 1;
  localparam int FST_VW = $clog2(FST_N) + 1;
  localparam int SEL_W  = $clog2(NRM_N);

  chanCmd_t          nrmCmd, fstCmd;
  logic [NRM_N-1:0]  nrmMask, nrmTrig, nrmPend;
  logic [FST_N-1:0]  fstMask, fstTrig, fstPend;
  logic [NRM_VW-1:0] nrmVec;
  logic [FST_VW-1:0] fstVec;
  logic              nrmValid, fstValid;
  logic [SEL_W-1:0]  routeSel6, routeSel7;
  logic [NRM_N-1:0]  nrmClean;
  logic [FST_N-1:0]  fstLines;

  assign nrmClean = nrmIrqIn & ~NRM_RSVD;
  assign fstLines = {nrmClean[routeSel7], nrmClean[routeSel6], fstIrqIn};

  vic_ctrl #(
    .NRM_N(NRM_N), .FST_N(FST_N), .NRM_VW(NRM_VW), .FST_VW(FST_VW), .SEL_W(SEL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWData(busWData), .busRData(busRData),
    .nrmCmd(nrmCmd), .fstCmd(fstCmd),
    .nrmMask(nrmMask), .nrmTrig(nrmTrig), .nrmPend(nrmPend),
    .nrmVec(nrmVec), .nrmValid(nrmValid),
    .fstMask(fstMask), .fstTrig(fstTrig), .fstPend(fstPend),
    .fstVec(fstVec), .fstValid(fstValid),
    .routeSel6(routeSel6), .routeSel7(routeSel7),
    .nrmReq(nrmReq), .fstReq(fstReq)
  );

  vic_chan_dp #(
    .N(NRM_N), .VEC_W(NRM_VW), .SYNC_STAGES(SYNC_STAGES),
    .TRIG_RST(NRM_TRIG_RST), .RSVD(NRM_RSVD)
  ) u_nrm (
    .clk(clk), .rstN(rstN), .irqIn(nrmClean), .cmd(nrmCmd), .wData(busWData),
    .maskQ(nrmMask), .trigQ(nrmTrig), .pendQ(nrmPend),
    .vecIdx(nrmVec), .vecValid(nrmValid)
  );

  vic_chan_dp #(
    .N(FST_N), .VEC_W(FST_VW), .SYNC_STAGES(SYNC_STAGES),
    .TRIG_RST(FST_TRIG_RST), .RSVD('0)
  ) u_fst (
    .clk(clk), .rstN(rstN), .irqIn(fstLines), .cmd(fstCmd), .wData(busWData[FST_N-1:0]),
    .maskQ(fstMask), .trigQ(fstTrig), .pendQ(fstPend),
    .vecIdx(fstVec), .vecValid(fstValid)
  );

endmodule

// File: tb/vic_dual_test.sv
module vic_dual_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] nrmIrqIn = '0;
  logic [5:0]  fstIrqIn = '0;
  logic [3:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] busWData = '0;
  logic [15:0] busRData;
  logic        nrmReq, fstReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t expQ[$];

  vic_dual uut (
    .clk(clk), .rstN(rstN), .nrmIrqIn(nrmIrqIn), .fstIrqIn(fstIrqIn),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busWData(busWData),
    .busRData(busRData), .nrmReq(nrmReq), .fstReq(fstReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compare read data a quarter period after the driving edge
  initial forever begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (busRd) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: read with no expected item, actual %h", busRData);
      end else begin
        item_t it;
        it = expQ.pop_front();
        checks++;
        if (busRData !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, busRData, it.exp);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, input logic [15:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic chkBit(input logic act, input logic e, input string tag);
    #1;
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, e);
    end
  endtask

  task automatic nrmPulse(input int b);
    @(negedge clk); nrmIrqIn[b] = 1'b1;
    cyc(2);          nrmIrqIn[b] = 1'b0;
    cyc(4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);

    // R1 reset state
    regRead(4'h0, 16'h0000, "R1 nrm mask");
    regRead(4'h1, 16'h0100, "R1 nrm trig");
    regRead(4'h9, 16'h0000, "R1 fst trig");
    regRead(4'h2, 16'h0000, "R1 nrm pend");
    regRead(4'h5, 16'h001F, "R1 nrm vec idle");
    regRead(4'hD, 16'h000F, "R1 fst vec idle");
    chkBit(nrmReq, 1'b0, "R1 nrmReq");
    chkBit(fstReq, 1'b0, "R1 fstReq");

    // R2 short pulse latched, R4 masked source held back
    nrmPulse(3);
    regRead(4'h2, 16'h0008, "R2 pulse pending");
    chkBit(nrmReq, 1'b0, "R4 masked no req");
    regRead(4'h5, 16'h001F, "R4 masked no vector");
    regWrite(4'h0, 16'hFFFF);
    chkBit(nrmReq, 1'b1, "R4 unmasked req");
    regRead(4'h5, 16'h0003, "R5 vector 3");

    // R12 two edges on source 1, R5 priority, R7 observe
    nrmPulse(1);
    nrmPulse(1);
    regRead(4'h2, 16'h000A, "R12 pend before ack");
    regRead(4'h5, 16'h0001, "R5 lower wins");
    regRead(4'h2, 16'h000A, "R7 peek no clear");
    chkBit(nrmReq, 1'b1, "R7 peek keeps req");
    regRead(4'h4, 16'h0001, "R6 ack returns vector");
    chkBit(nrmReq, 1'b0, "R6 in service");
    regRead(4'h2, 16'h0008, "R12 one ack clears");
    regWrite(4'h3, 16'h0000);
    chkBit(nrmReq, 1'b1, "R8 eoi releases");
    regRead(4'h4, 16'h0003, "R6 ack second");
    regRead(4'h2, 16'h0000, "R6 pend cleared");
    regWrite(4'h3, 16'h0000);
    chkBit(nrmReq, 1'b0, "R8 eoi nothing pending");
    regRead(4'h5, 16'h001F, "R5 idle again");

    // R3 level on normal 8
    @(negedge clk); nrmIrqIn[8] = 1'b1;
    cyc(4);
    regRead(4'h2, 16'h0100, "R3 level pending");
    chkBit(nrmReq, 1'b1, "R3 level req");
    regRead(4'h4, 16'h0008, "R6 ack level");
    regRead(4'h2, 16'h0100, "R6 level stays");
    chkBit(nrmReq, 1'b0, "R6 level in service");
    regWrite(4'h3, 16'h0000);
    chkBit(nrmReq, 1'b1, "R8 eoi level");
    @(negedge clk); nrmIrqIn[8] = 1'b0;
    cyc(4);
    regRead(4'h2, 16'h0000, "R3 level drops");
    chkBit(nrmReq, 1'b0, "R3 no req");

    // R3 programmed level on fast 0
    regWrite(4'h9, 16'h0001);
    regWrite(4'h8, 16'h00FF);
    @(negedge clk); fstIrqIn[0] = 1'b1;
    cyc(4);
    regRead(4'hA, 16'h0001, "R3 fast level");
    chkBit(fstReq, 1'b1, "R3 fast req");
    @(negedge clk); fstIrqIn[0] = 1'b0;
    cyc(4);
    regRead(4'hA, 16'h0000, "R3 fast level drops");

    // R9 write-one-to-clear
    nrmPulse(5);
    nrmPulse(6);
    regRead(4'h2, 16'h0060, "R9 before clear");
    regWrite(4'h2, 16'h0020);
    regRead(4'h2, 16'h0040, "R9 only bit 5 cleared");
    regWrite(4'h2, 16'h0040);

    // R10 reserved inputs
    @(negedge clk); nrmIrqIn[7] = 1'b1; nrmIrqIn[14] = 1'b1;
    cyc(4);
    regRead(4'h2, 16'h0000, "R10 reserved quiet");
    chkBit(nrmReq, 1'b0, "R10 no req");
    @(negedge clk); nrmIrqIn[7] = 1'b0; nrmIrqIn[14] = 1'b0;

    // R11 routing to fast 6 and 7
    regWrite(4'hE, 16'h0902);
    regRead(4'hE, 16'h0902, "R11 route readback");
    nrmPulse(2);
    regRead(4'hA, 16'h0040, "R11 fast6 from nrm2");
    regRead(4'hD, 16'h0006, "R11 fast vector 6");
    nrmPulse(9);
    regRead(4'hA, 16'h00C0, "R11 fast7 from nrm9");
    regRead(4'hC, 16'h0006, "R6 fast ack");
    chkBit(fstReq, 1'b0, "R6 fast in service");
    regRead(4'hA, 16'h0080, "R6 fast pend cleared");
    regWrite(4'hB, 16'h0000);
    chkBit(fstReq, 1'b1, "R8 fast eoi");
    regWrite(4'hA, 16'h0080);
    regRead(4'hA, 16'h0000, "R9 fast clear");
    regWrite(4'h2, 16'hFFFF);
    regRead(4'h2, 16'h0000, "R9 nrm clear all");

    // R2 short pulse on fast input 1
    @(negedge clk); fstIrqIn[1] = 1'b1;
    cyc(2);          fstIrqIn[1] = 1'b0;
    cyc(4);
    regRead(4'hA, 16'h0002, "R2 fast pulse held");
    regRead(4'hD, 16'h0001, "R2 fast vector");

    cyc(2);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", expQ.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule